// File: doc/BRIEF.md
# High-Side Current-Sense Blanking Controller

This block decides, cycle by cycle, when the high-side overcurrent comparator may be trusted inside each switching period. A cycle-start strobe opens a period. For one clock before the high-side gate command rises, and then while the gate is on, the block raises a precondition output that pulls the current-limit reference to an intermediate level and masks the raw overcurrent flag. The precondition drops as soon as the switch-node comparator reports the switch node near the supply, or when a blanking timeout counted in clock cycles runs out, whichever comes first.

After release, the first raw overcurrent seen produces a single-cycle qualified trip pulse. The trip ends the high-side pulse, but never before a minimum on-time has elapsed, so the switch cannot be chopped into slivers under a short circuit. A PWM end request ends the pulse at once when no trip is pending. When the gate falls, the block returns to idle and waits for the next cycle-start strobe.

Top module: `hs_sense_blank_ctrl`

## Requirements
- R1: A cycle-start strobe sampled in idle raises precond_o at the next clock edge, and hs_gate_o rises one clock later. precond_o stays high through the first on-cycle of the gate.
- R2: While the gate is on and precond_o is high, a high sw_high_i sampled at a clock edge clears precond_o at that edge.
- R3: Without sw_high_i, precond_o clears after BLANK_CYC gate-on cycles. With the default of 12, precond_o is high for 13 cycles in total.
- R4: oc_raw_i has no effect while precond_o is high or the gate is off. No trip is issued and the gate width is unchanged.
- R5: A high oc_raw_i sampled while sensing is enabled gives oc_trip_o high for exactly one cycle, in the cycle after the sample.
- R6: At most one oc_trip_o pulse is issued per switching period, even when oc_raw_i stays high.
- R7: After a trip, the gate stays on for at least MIN_ON_CYC cycles in total (default 22), and pwm_end_i is ignored until then. If the minimum has already been met, the gate drops at the edge after the trip sample.
- R8: Without a trip, a high pwm_end_i sampled while the gate is on drops hs_gate_o and precond_o at that edge, and the block re-arms for the next strobe. If oc_raw_i and pwm_end_i are sampled in the same sensing cycle, the trip takes priority.
- R9: A cycle-start strobe sampled while a period is in progress is ignored.
- R10: While rst_n is low, including in the middle of a period, precond_o, hs_gate_o and oc_trip_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start_i | input | 1 | Switching-period start strobe |
| pwm_end_i | input | 1 | PWM request to end the high-side pulse |
| sw_high_i | input | 1 | Switch node is near the supply (comparator flag) |
| oc_raw_i | input | 1 | Unqualified high-side overcurrent comparator flag |
| precond_o | output | 1 | Pulls the current-limit reference to its intermediate level |
| hs_gate_o | output | 1 | High-side gate command |
| oc_trip_o | output | 1 | Qualified overcurrent pulse, one cycle |

## Verification
The assertions check on every cycle that:
- the gate only rises after a precondition cycle;
- the switch-node flag releases the precondition at once;
- the blanking counter stays below its limit;
- a trip only follows a sample taken with sensing enabled;
- only one trip is issued per period;
- a tripped pulse never falls before the minimum width;
- a start strobe during a period never re-arms the block.

Only the bench scenarios can show the exact precondition lengths, the pulse widths and the trip timing for each mix of switch-node timing, overcurrent windows and PWM end requests. The same holds for the same-cycle priority cases and for recovery after a reset in the middle of a period.

// File: rtl/cs_sense_pkg.sv
package cs_sense_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ARM   = 3'd1,
    PH_BLANK = 3'd2,
    PH_SENSE = 3'd3,
    PH_HOLD  = 3'd4
  } phase_t;

  // true on the last permitted blanking cycle (elapsed counts from zero)
  function automatic logic blank_expired(input int elapsed, input int limit);
    return (elapsed >= limit - 1);
  endfunction

  // true when the current gate-on cycle index completes the minimum width
  function automatic logic min_width_met(input int idx, input int min_on);
    return (idx >= min_on - 1);
  endfunction

  // saturating increment
  function automatic int sat_inc(input int v, input int cap);
    return (v >= cap) ? cap : v + 1;
  endfunction

endpackage

// File: rtl/cs_blank_timer.sv
module cs_blank_timer
  import cs_sense_pkg::*;
#(
  parameter int BLANK_CYC = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  input  logic sw_high_i,
  output logic release_o,
  output logic timeout_o
);

  localparam int BW = $clog2(BLANK_CYC + 1);

  logic [BW-1:0] elapsed_q;
  logic          limit_hit;

  assign limit_hit = blank_expired(int'(elapsed_q), BLANK_CYC);
  assign timeout_o = run_i && limit_hit;
  assign release_o = run_i && (sw_high_i || limit_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed_q <= '0;
    end else if (clear_i) begin
      elapsed_q <= '0;
    end else if (run_i && !release_o) begin
      elapsed_q <= BW'(sat_inc(int'(elapsed_q), BLANK_CYC));
    end
  end

  // blanking never runs past its limit
  assert_blank_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (int'(elapsed_q) < BLANK_CYC));

endmodule

// File: rtl/cs_ontime_counter.sv
module cs_ontime_counter
  import cs_sense_pkg::*;
#(
  parameter int MIN_ON_CYC = 22
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             clear_i,
  input  logic                             gate_i,
  output logic                             min_met_o,
  output logic [$clog2(MIN_ON_CYC+1)-1:0]  width_o
);

  localparam int OW = $clog2(MIN_ON_CYC + 1);

  logic [OW-1:0] on_q;

  // on_q holds the index of the current gate-on cycle while the gate is high
  assign min_met_o = min_width_met(int'(on_q), MIN_ON_CYC);
  assign width_o   = on_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q <= '0;
    end else if (clear_i) begin
      on_q <= '0;
    end else if (gate_i) begin
      on_q <= OW'(sat_inc(int'(on_q), MIN_ON_CYC));
    end
  end

  assert_on_saturates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(on_q) == MIN_ON_CYC) |=> (int'(on_q) == MIN_ON_CYC) || $past(clear_i));

endmodule

// File: rtl/cs_oc_qualifier.sv
module cs_oc_qualifier (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic sense_en_i,
  input  logic oc_raw_i,
  output logic trip_now_o,
  output logic tripped_o,
  output logic oc_trip_o
);

  logic tripped_q;
  logic trip_q;

  assign trip_now_o = sense_en_i && oc_raw_i && !tripped_q;
  assign tripped_o  = tripped_q;
  assign oc_trip_o  = trip_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tripped_q <= 1'b0;
      trip_q    <= 1'b0;
    end else begin
      trip_q <= trip_now_o;
      if (clear_i) begin
        tripped_q <= 1'b0;
      end else if (trip_now_o) begin
        tripped_q <= 1'b1;
      end
    end
  end

  // a trip only follows a sample taken with sensing enabled
  assert_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    oc_trip_o |-> $past(sense_en_i && oc_raw_i));

  // single-cycle pulse
  assert_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    oc_trip_o |=> !oc_trip_o);

  // only one trip per period
  assert_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    oc_trip_o |-> !$past(tripped_q));

endmodule

// File: rtl/hs_sense_blank_ctrl.sv
module hs_sense_blank_ctrl
  import cs_sense_pkg::*;
#(
  parameter int BLANK_CYC  = 12,
  parameter int MIN_ON_CYC = 22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start_i,
  input  logic pwm_end_i,
  input  logic sw_high_i,
  input  logic oc_raw_i,
  output logic precond_o,
  output logic hs_gate_o,
  output logic oc_trip_o
);

  localparam int OW = $clog2(MIN_ON_CYC + 1);

  phase_t phase_q, phase_d;

  // internal events brought out as named wires
  logic          ev_arm;
  logic          ev_blank;
  logic          ev_sense;
  logic          ev_release;
  logic          ev_timeout;
  logic          ev_trip_now;
  logic          ev_tripped;
  logic          ev_min_met;
  logic [OW-1:0] on_width;

  assign ev_arm   = (phase_q == PH_ARM);
  assign ev_blank = (phase_q == PH_BLANK);
  assign ev_sense = (phase_q == PH_SENSE);

  assign precond_o = ev_arm || ev_blank;
  assign hs_gate_o = ev_blank || ev_sense || (phase_q == PH_HOLD);

  cs_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (ev_arm),
    .run_i     (ev_blank),
    .sw_high_i (sw_high_i),
    .release_o (ev_release),
    .timeout_o (ev_timeout)
  );

  cs_ontime_counter #(.MIN_ON_CYC(MIN_ON_CYC)) u_ontime (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (ev_arm),
    .gate_i    (hs_gate_o),
    .min_met_o (ev_min_met),
    .width_o   (on_width)
  );

  cs_oc_qualifier u_qual (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (ev_arm),
    .sense_en_i (ev_sense),
    .oc_raw_i   (oc_raw_i),
    .trip_now_o (ev_trip_now),
    .tripped_o  (ev_tripped),
    .oc_trip_o  (oc_trip_o)
  );

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:  if (cyc_start_i) phase_d = PH_ARM;
      PH_ARM:   phase_d = PH_BLANK;
      PH_BLANK: begin
        if (pwm_end_i)       phase_d = PH_IDLE;
        else if (ev_release) phase_d = PH_SENSE;
      end
      PH_SENSE: begin
        if (ev_trip_now)     phase_d = ev_min_met ? PH_IDLE : PH_HOLD;
        else if (pwm_end_i)  phase_d = PH_IDLE;
      end
      PH_HOLD:  if (ev_min_met) phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  // precondition leads the gate
  assert_precond_lead_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate_o) |-> $past(precond_o));

  // switch-node flag releases at once
  assert_sw_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_blank && sw_high_i && !pwm_end_i) |=> (!precond_o && hs_gate_o));

  // timeout releases into sensing
  assert_timeout_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_timeout && !pwm_end_i) |=> ev_sense);

  // minimum width after a trip
  assert_min_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hs_gate_o) && ev_tripped) |-> (int'(on_width) >= MIN_ON_CYC));

  // PWM end stops an untripped pulse
  assert_end_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_end_i && (ev_blank || (ev_sense && !oc_raw_i))) |=> !hs_gate_o);

  // start strobe ignored mid-period
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start_i && phase_q != PH_IDLE) |=> !ev_arm);

endmodule

// File: tb/hs_sense_blank_ctrl_tb.sv
module hs_sense_blank_ctrl_tb;

  localparam int BLANK = 12;
  localparam int MINON = 22;
  localparam int NV    = 13;
  localparam int NONE  = 99;

  // columns: sw_at, oc_at, oc_len, end_at, extra_start, exp_pre, exp_width, exp_trips, exp_trip_k
  localparam int VEC [NV][9] = '{
    '{3,    NONE, 0,  30, NONE, 5,  31, 0, -1},  // R2 R8
    '{NONE, NONE, 0,  30, NONE, 13, 31, 0, -1},  // R3
    '{0,    10,   1,  40, NONE, 2,  22, 1, 11},  // R5 R7
    '{NONE, 5,    3,  30, NONE, 13, 31, 0, -1},  // R4
    '{NONE, 8,    10, 40, NONE, 13, 22, 1, 13},  // R4 R6
    '{2,    25,   20, 40, NONE, 4,  26, 1, 26},  // R6
    '{5,    8,    1,  10, NONE, 7,  22, 1, 9},   // R7 end ignored
    '{NONE, 3,    1,  6,  NONE, 8,  7,  0, -1},  // R8 end in blanking, R4
    '{12,   NONE, 0,  20, NONE, 13, 21, 0, -1},  // R3 timeout first
    '{0,    NONE, 0,  30, 5,    2,  31, 0, -1},  // R9
    '{11,   12,   1,  30, NONE, 13, 22, 1, 13},  // R2 R3 same cycle
    '{0,    21,   1,  40, NONE, 2,  22, 1, 22},  // R7 boundary
    '{0,    30,   1,  30, NONE, 2,  31, 1, 31}   // R8 priority
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_start_i = 1'b0;
  logic pwm_end_i = 1'b0;
  logic sw_high_i = 1'b0;
  logic oc_raw_i = 1'b0;
  logic precond_o, hs_gate_o, oc_trip_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  hs_sense_blank_ctrl #(.BLANK_CYC(BLANK), .MIN_ON_CYC(MINON)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_start_i (cyc_start_i),
    .pwm_end_i   (pwm_end_i),
    .sw_high_i   (sw_high_i),
    .oc_raw_i    (oc_raw_i),
    .precond_o   (precond_o),
    .hs_gate_o   (hs_gate_o),
    .oc_trip_o   (oc_trip_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_period(input int v);
    int n_pre = 0, n_gate = 0, n_trip = 0, trip_k = -1, gidx = 0;
    @(negedge clk);
    cyc_start_i = 1'b1;
    @(negedge clk);
    cyc_start_i = 1'b0;
    for (int n = 0; n < 80; n++) begin
      int g;
      if (precond_o) n_pre++;
      if (hs_gate_o) begin
        g = gidx;
        gidx++;
        n_gate++;
      end else begin
        g = -1;
      end
      if (oc_trip_o) begin
        n_trip++;
        trip_k = (g >= 0) ? g : gidx;
      end
      sw_high_i   = (g >= 0) && (g >= VEC[v][0]);
      oc_raw_i    = (g >= 0) && (g >= VEC[v][1]) && (g < VEC[v][1] + VEC[v][2]);
      pwm_end_i   = (g >= 0) && (g == VEC[v][3]);
      cyc_start_i = (g >= 0) && (g == VEC[v][4]);
      @(negedge clk);
    end
    sw_high_i = 1'b0; oc_raw_i = 1'b0; pwm_end_i = 1'b0; cyc_start_i = 1'b0;
    check($sformatf("R1 R2 R3 precond cycles v%0d", v), n_pre, VEC[v][5]);
    check($sformatf("R7 R8 R9 gate width v%0d", v), n_gate, VEC[v][6]);
    check($sformatf("R4 R6 trip count v%0d", v), n_trip, VEC[v][7]);
    check($sformatf("R5 trip timing v%0d", v), trip_k, VEC[v][8]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs low during reset
    check("R10 precond in reset", int'(precond_o), 0);
    check("R10 gate in reset", int'(hs_gate_o), 0);
    check("R10 trip in reset", int'(oc_trip_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) run_period(v);

    // R10: reset in the middle of a period
    cyc_start_i = 1'b1;
    @(negedge clk);
    cyc_start_i = 1'b0;
    sw_high_i = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 gate on before mid reset", int'(hs_gate_o), 1);
    rst_n = 1'b0;
    #1;
    check("R10 precond mid reset", int'(precond_o), 0);
    check("R10 gate mid reset", int'(hs_gate_o), 0);
    check("R10 trip mid reset", int'(oc_trip_o), 0);
    sw_high_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run_period(2);   // R8 re-arm after reset

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule